// File: doc/BRIEF.md
# Serial Wiper Position Receiver

This block takes an 8-bit resistor-tap position from a three-wire serial link that only writes. The link has a select line (active low), a serial clock and a data line. There is no return path. All three lines are asynchronous to the system clock. Each line passes through a two-flop synchronizer, and every edge is detected in the system clock domain. For this to work, the system clock must run at least four times faster than the serial clock.

A frame begins when select falls. While select is low, each rising serial clock edge shifts one data bit in, most significant bit first. The frame is committed when select rises again. A frame of fewer than eight bits is discarded. A longer frame commits its last eight bits. The held position drives a 256-way tap selector. It starts at mid-scale. A single-cycle strobe marks each commit.

Top module: `wiper_spi_rx`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `wiper_code` reads 0x80 and `wiper_upd` is low.
- R2: Data is taken on each rising edge of `ser_clk` while `ser_sel_n` is low. The first bit of a frame lands in bit 7 of `wiper_code` and the eighth bit lands in bit 0.
- R3: `wiper_code` never changes while `ser_sel_n` stays low. A frame takes effect only on the low-to-high transition of `ser_sel_n`.
- R4: `wiper_upd` is high for exactly one system cycle. In that cycle `wiper_code` first shows the new value. The pulse comes at the third rising system edge that samples `ser_sel_n` high. In every other cycle `wiper_code` holds its value.
- R5: A falling edge on `ser_sel_n` clears the bit count. Bits from an earlier frame never count toward the next one.
- R6: A frame with fewer than 8 bits leaves `wiper_code` unchanged and gives no `wiper_upd` pulse.
- R7: A frame with more than 8 bits commits the last 8 bits received.
- R8: Rising edges of `ser_clk` while `ser_sel_n` is high shift nothing and count nothing.
- R9: If a `ser_clk` rising edge and the `ser_sel_n` rising edge reach the synchronizer outputs in the same cycle, that clock edge is ignored, and the eight bits received before it are committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_sel_n | input | 1 | Serial select, active low, asynchronous |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_din | input | 1 | Serial data, sent most significant bit first |
| wiper_code | output | WORD_W (8) | Committed tap position |
| wiper_upd | output | 1 | One-cycle strobe on each commit |

## Verification
Two events can be decoded in the same system cycle: a shift caused by a serial clock edge, and a commit or clear caused by a select edge. The bench forces this by driving `ser_clk` high and `ser_sel_n` high on the same system edge after a full frame. It checks that the extra edge is dropped and that the eight earlier bits are committed. A second case raises a serial clock edge together with the select falling edge, and checks that it is not counted. A behavioural model built from the pin history judges every cycle. Explicit value checks after each frame confirm the expected position.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  localparam int DEF_WORD_W      = 8;
  localparam int DEF_SYNC_STAGES = 2;
  localparam int NUM_PINS        = 3;

  typedef enum int {
    PIN_SEL = 0,
    PIN_SCK = 1,
    PIN_DIN = 2
  } pin_idx_e;
endpackage

// File: rtl/wiper_sync_edge.sv
module wiper_sync_edge #(
  parameter int             N      = 3,
  parameter int             STAGES = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] lvl,
  output logic [N-1:0] prv
);
  localparam int DEPTH = STAGES + 1;

  logic [N-1:0] chain [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= async_in;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[g] <= RST_VAL;
      else     chain[g] <= chain[g-1];
    end
  end

  assign lvl = chain[STAGES-1];
  assign prv = chain[STAGES];
endmodule

// File: rtl/wiper_shift_rx.sv
module wiper_shift_rx #(
  parameter int WORD_W = 8,
  localparam int CNT_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_low,
  input  logic              sel_fall,
  input  logic              sck_rise,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              full
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  always_ff @(posedge clk) begin
    if (rst) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (sel_fall) begin
      word    <= '0;
      bit_cnt <= '0;
    end else if (sel_low && sck_rise) begin
      word <= {word[WORD_W-2:0], din};
      if (bit_cnt != FULL_CNT) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign full = (bit_cnt == FULL_CNT);
endmodule

// File: rtl/wiper_ctrl_reg.sv
module wiper_ctrl_reg #(
  parameter int                WORD_W     = 8,
  parameter logic [WORD_W-1:0] RESET_CODE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [WORD_W-1:0] new_code,
  output logic [WORD_W-1:0] code,
  output logic              upd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code <= RESET_CODE;
      upd  <= 1'b0;
    end else begin
      upd <= commit;
      if (commit) code <= new_code;
    end
  end
endmodule

// File: rtl/wiper_spi_rx.sv
module wiper_spi_rx
  import wiper_pkg::*;
#(
  parameter int                WORD_W      = DEF_WORD_W,
  parameter int                SYNC_STAGES = DEF_SYNC_STAGES,
  parameter logic [WORD_W-1:0] RESET_CODE  = WORD_W'(1) << (WORD_W - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_sel_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic [WORD_W-1:0] wiper_code,
  output logic              wiper_upd
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [NUM_PINS-1:0] PIN_IDLE = NUM_PINS'(1) << int'(PIN_SEL);

  logic [NUM_PINS-1:0] pins_raw, pins_lvl, pins_prv;
  logic                sel_rise, sel_fall, sel_low, sck_rise;
  logic [WORD_W-1:0]   rx_word;
  logic [CNT_W-1:0]    bit_cnt;
  logic                rx_full;

  always_comb begin
    pins_raw = '0;
    pins_raw[int'(PIN_SEL)] = ser_sel_n;
    pins_raw[int'(PIN_SCK)] = ser_clk;
    pins_raw[int'(PIN_DIN)] = ser_din;
  end

  wiper_sync_edge #(
    .N(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .async_in(pins_raw), .lvl(pins_lvl), .prv(pins_prv)
  );

  assign sel_low  = ~pins_lvl[int'(PIN_SEL)];
  assign sel_rise =  pins_lvl[int'(PIN_SEL)] & ~pins_prv[int'(PIN_SEL)];
  assign sel_fall = ~pins_lvl[int'(PIN_SEL)] &  pins_prv[int'(PIN_SEL)];
  assign sck_rise =  pins_lvl[int'(PIN_SCK)] & ~pins_prv[int'(PIN_SCK)];

  wiper_shift_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .sel_low(sel_low), .sel_fall(sel_fall),
    .sck_rise(sck_rise), .din(pins_lvl[int'(PIN_DIN)]),
    .word(rx_word), .bit_cnt(bit_cnt), .full(rx_full)
  );

  wiper_ctrl_reg #(.WORD_W(WORD_W), .RESET_CODE(RESET_CODE)) u_reg (
    .clk(clk), .rst(rst), .commit(sel_rise & rx_full), .new_code(rx_word),
    .code(wiper_code), .upd(wiper_upd)
  );
endmodule

// File: rtl/wiper_spi_chk.sv
module wiper_spi_chk #(
  parameter int                WORD_W     = 8,
  parameter logic [WORD_W-1:0] RESET_CODE = '0,
  localparam int               CNT_W      = $clog2(WORD_W + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              ser_sel_n,
  input logic              sel_rise,
  input logic              sel_fall,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [WORD_W-1:0] wiper_code,
  input logic              wiper_upd
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

  assert_reset_mid_R1: assert property (@(posedge clk)
    $past(rst) |-> (wiper_code == RESET_CODE && !wiper_upd));

  // R3: a commit can only follow a select rising edge
  assert_commit_on_sel_rise_R3: assert property (@(posedge clk) disable iff (rst)
    wiper_upd |-> $past(sel_rise));

  assert_hold_without_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    !wiper_upd |-> $stable(wiper_code));

  assert_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
    wiper_upd |=> !wiper_upd);

  assert_count_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    sel_fall |=> (bit_cnt == '0));

  assert_short_frame_dropped_R6: assert property (@(posedge clk) disable iff (rst)
    (sel_rise && bit_cnt != FULL_CNT) |=> !wiper_upd);

  // R3: the selected serial line is low for the whole frame, so no commit then
  assert_no_update_mid_frame_R3: assert property (@(posedge clk) disable iff (rst)
    ($past(ser_sel_n) == 1'b0 && ser_sel_n == 1'b0 && !sel_rise) |=> !wiper_upd || $past(sel_rise));
endmodule

bind wiper_spi_rx wiper_spi_chk #(.WORD_W(WORD_W), .RESET_CODE(RESET_CODE)) u_chk (
  .clk(clk), .rst(rst), .ser_sel_n(ser_sel_n), .sel_rise(sel_rise), .sel_fall(sel_fall),
  .bit_cnt(bit_cnt), .wiper_code(wiper_code), .wiper_upd(wiper_upd)
);

// File: tb/test_wiper_spi_rx.sv
module test_wiper_spi_rx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, sck = 1'b0, din = 1'b0;
  logic [7:0] code;
  logic upd;

  int checks = 0, errors = 0, cycles = 0, pulses = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // sync history of pins: index 0 newest
  logic h_sel [4];
  logic h_sck [4];
  logic h_din [4];
  int   m_cnt = 0, m_shift = 0, m_code = 'h80;
  bit   m_upd = 1'b0;

  always #2.5 clk = ~clk;

  wiper_spi_rx i_wiper_spi_rx (
    .clk(clk), .rst(rst), .ser_sel_n(sel_n), .ser_clk(sck), .ser_din(din),
    .wiper_code(code), .wiper_upd(upd)
  );

  // behavioural reference
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin
        h_sel[i] = 1'b1; h_sck[i] = 1'b0; h_din[i] = 1'b0;
      end
      m_cnt = 0; m_shift = 0; m_code = 'h80; m_upd = 1'b0;
    end else begin
      for (int i = 3; i > 0; i--) begin
        h_sel[i] = h_sel[i-1]; h_sck[i] = h_sck[i-1]; h_din[i] = h_din[i-1];
      end
      h_sel[0] = sel_n; h_sck[0] = sck; h_din[0] = din;
      m_upd = 1'b0;
      if (h_sel[2] && !h_sel[3]) begin
        if (m_cnt >= 8) begin
          m_code = m_shift & 'hff;
          m_upd  = 1'b1;
        end
      end else if (!h_sel[2] && h_sel[3]) begin
        m_cnt = 0; m_shift = 0;
      end else if (!h_sel[2] && h_sck[2] && !h_sck[3]) begin
        m_shift = ((m_shift << 1) | int'(h_din[2])) & 'hff;
        if (m_cnt < 8) m_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst && !done) begin
      checks++;
      if (code !== m_code[7:0] || upd !== m_upd) begin
        errors++;
        $display("FAIL %s cycle %0d: code=%02h upd=%0b expected code=%02h upd=%0b",
                 cur_req, cycles, code, upd, m_code[7:0], m_upd);
      end
      if (upd === 1'b1) pulses++;
    end
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic send_bit(logic b);
    din = b;
    wait_cyc(4);
    sck = 1'b1;
    wait_cyc(4);
    sck = 1'b0;
  endtask

  task automatic frame(int value, int nbits);
    sel_n = 1'b0;
    wait_cyc(4);
    for (int i = nbits - 1; i >= 0; i--) send_bit(logic'((value >> i) & 1));
    wait_cyc(4);
    sel_n = 1'b1;
    wait_cyc(8);
  endtask

  initial begin
    int p0;
    wait_cyc(3);
    check_val("R1", int'(code), 'h80);
    check_val("R1", int'(upd), 0);
    rst = 1'b0;
    @(negedge clk);
    check_val("R1", int'(code), 'h80);
    wait_cyc(4);

    cur_req = "R2"; p0 = pulses;
    frame('hA5, 8);
    check_val("R2", int'(code), 'hA5);
    check_val("R4", pulses - p0, 1);

    // R4 latency: pulse at third edge sampling select high
    cur_req = "R4";
    sel_n = 1'b0; wait_cyc(4);
    for (int i = 7; i >= 0; i--) send_bit(logic'(('h3C >> i) & 1));
    wait_cyc(4);
    cur_req = "R3";
    check_val("R3", int'(code), 'hA5);
    sel_n = 1'b1;
    wait_cyc(2);
    check_val("R4", int'(upd), 0);
    @(negedge clk);
    check_val("R4", int'(upd), 1);
    check_val("R4", int'(code), 'h3C);
    wait_cyc(8);

    cur_req = "R2";
    frame('hFF, 8); check_val("R2", int'(code), 'hFF);
    frame('h00, 8); check_val("R2", int'(code), 'h00);
    frame('h96, 8); check_val("R2", int'(code), 'h96);

    cur_req = "R6"; p0 = pulses;
    frame('h1F, 5);
    check_val("R6", int'(code), 'h96);
    check_val("R6", pulses - p0, 0);

    cur_req = "R5"; p0 = pulses;
    frame('h15, 5);
    frame('h0A, 4);
    check_val("R5", int'(code), 'h96);
    check_val("R5", pulses - p0, 0);

    cur_req = "R7";
    frame('h7C3, 11);
    check_val("R7", int'(code), 'hC3);

    cur_req = "R8"; p0 = pulses;
    for (int i = 0; i < 4; i++) send_bit(logic'(i & 1));
    frame('h0B, 4);
    check_val("R8", int'(code), 'hC3);
    check_val("R8", pulses - p0, 0);

    // R9: ninth clock edge lands with select rising
    cur_req = "R9";
    sel_n = 1'b0; wait_cyc(4);
    for (int i = 7; i >= 0; i--) send_bit(logic'(('h5A >> i) & 1));
    din = 1'b1; wait_cyc(4);
    sck = 1'b1; sel_n = 1'b1;
    wait_cyc(4); sck = 1'b0; wait_cyc(8);
    check_val("R9", int'(code), 'h5A);

    // R9: clock edge together with select falling is not counted
    sck = 1'b1; sel_n = 1'b0; din = 1'b1;
    wait_cyc(4); sck = 1'b0;
    for (int i = 6; i >= 0; i--) send_bit(logic'(('h11 >> i) & 1));
    wait_cyc(4); sel_n = 1'b1; wait_cyc(8);
    check_val("R9", int'(code), 'h5A);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule